// File: doc/BRIEF.md
# Panel-Aware GPIO Data Register

This block holds the data and direction bits for a small bank of general-purpose pins on a display controller. Some of these pins can be taken over by the LCD interface when a panel type is selected. When no panel mode claims a pin, the pin works as an ordinary GPIO. As an output it drives the stored data bit. As an input it returns its own level through a two-flop synchronizer.

Two 2-bit panel-select inputs decide which pins are claimed. Every cycle, each pin falls into one of four ownership states:
- `OWN_IN`: free pin, direction 0.
- `OWN_OUT`: free pin, direction 1.
- `OWN_GATE`: the stored bit enables a panel control signal, or forces it low.
- `OWN_LOCK`: the panel drives the pin, and writes to its data bit are dropped.

A pin moves between `OWN_IN` and `OWN_OUT` when software writes the direction register. A pin enters `OWN_GATE` or `OWN_LOCK` on the cycle a select field claims it, and returns to its direction-based state on the cycle the claim is released. The pin's register bit is kept across all of these changes.

Software reaches the block through a one-cycle write strobe and a combinational read port. Address 0 is the data register and address 1 is the direction register. Panel timing is produced elsewhere and arrives as plain inputs: a reset control, a common-drive control and one lane per locked pin.

Top module: `panel_gpio_reg`

## Requirements
- R1: After reset, every data bit and every direction bit is 0. With no panel mode selected, every pin then has output enable 0. A gated panel signal then reads 0 on its pin.
- R2: A free pin with direction 1 drives `pin_out` with the last value written to its data bit, and holds `pin_oe` at 1. The new value shows after the clock edge that takes the write.
- R3: A free pin with direction 0 has `pin_oe` 0. Its data-register read bit returns the pin level two clock edges after the level is applied, not one.
- R4: Field `sel_a` = 11 selects the gated-reset panel and `sel_a` = 10 selects the fixed-control panel. Field `sel_b` = 01 selects the strobe panel and `sel_b` = 10 selects the common-drive panel. The codes `sel_a` = 00/01 and `sel_b` = 00/11 claim nothing.
- R5: In gated-reset mode, pin 4 is an output carrying `panel_rst_in` AND data bit 4. Writing 0 to bit 4 forces the pin low.
- R6: In common-drive mode, pin 4 is an output carrying `panel_com_in` AND data bit 4. When both gated-reset and common-drive are selected, the reset signal takes the pin.
- R7: In any of the four panel modes, writes to data bits 2 and 3 leave them unchanged. Pins 2 and 3 are then outputs driven from `lcd_drv[2]` and `lcd_drv[3]`. Once the mode is released, those bits accept writes again.
- R8: A read of a claimed pin's data bit returns the stored register value, not the pin level.
- R9: A write to address 1 loads the direction register, and a read of address 1 returns it. Addresses 2 and 3 read as 0 and ignore writes.
- R10: Pins 0 and 1 are never claimed. Their output enable follows their direction bit in every panel mode. The output enable of a claimed pin does not depend on its direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | One-cycle register write strobe |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Read data for `bus_addr` (combinational) |
| sel_a | input | 2 | First panel-type select field |
| sel_b | input | 2 | Second panel-type select field |
| panel_rst_in | input | 1 | Panel reset control from timing logic |
| panel_com_in | input | 1 | Panel common-drive control from timing logic |
| lcd_drv | input | NUM_PINS | Panel drive lanes for locked pins |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Pad output values |
| pin_oe | output | NUM_PINS | Pad output enables |

## Verification
The bench samples an input read after one edge and again after two edges. A design with one synchronizer stage too few or too many returns the new level at the wrong sample. It writes 0 to the locked bits while a panel mode is active and reads them back after releasing the mode. A design that lets the write through shows 0 where 1 is expected. With both select fields claiming pin 4, it toggles only the common-drive source, so a design that picks the wrong source for the pin gives the wrong output. It also clears the direction register while a panel mode holds pin 4. A design that lets the direction bit reach a claimed pin's enable then turns that pin off.

// File: rtl/gpio_panel_pkg.sv
package gpio_panel_pkg;

    // Ownership class of one pin, re-evaluated every cycle
    typedef enum logic [1:0] {
        OWN_IN   = 2'd0,
        OWN_OUT  = 2'd1,
        OWN_GATE = 2'd2,
        OWN_LOCK = 2'd3
    } pin_own_e;

    // First panel-select field encodings
    typedef enum logic [1:0] {
        SELA_NONE  = 2'b00,
        SELA_RSV   = 2'b01,
        SELA_FIXED = 2'b10,
        SELA_GRST  = 2'b11
    } sel_a_e;

    // Second panel-select field encodings
    typedef enum logic [1:0] {
        SELB_NONE = 2'b00,
        SELB_STRB = 2'b01,
        SELB_COM  = 2'b10,
        SELB_RSV  = 2'b11
    } sel_b_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/gpio_own_decode.sv
module gpio_own_decode
    import gpio_panel_pkg::*;
#(
    parameter int                  NUM_PINS  = 5,
    parameter int                  GATE_PIN  = 4,
    parameter logic [NUM_PINS-1:0] LOCK_MASK = 5'b01100
) (
    input  logic [1:0]                  sel_a,
    input  logic [1:0]                  sel_b,
    input  logic [NUM_PINS-1:0]         dir_q,
    output pin_own_e [NUM_PINS-1:0]     own_o,
    output logic                        gate_use_com
);

    logic lock_claim_a;
    logic lock_claim_b;
    logic gate_rst;
    logic gate_com;
    logic gate_claim;

    always_comb begin
        lock_claim_a = 1'b0;
        gate_rst     = 1'b0;
        unique case (sel_a_e'(sel_a))
            SELA_GRST: begin
                lock_claim_a = 1'b1;
                gate_rst     = 1'b1;
            end
            SELA_FIXED: lock_claim_a = 1'b1;
            SELA_NONE, SELA_RSV: ;
        endcase
    end

    always_comb begin
        lock_claim_b = 1'b0;
        gate_com     = 1'b0;
        unique case (sel_b_e'(sel_b))
            SELB_COM: begin
                lock_claim_b = 1'b1;
                gate_com     = 1'b1;
            end
            SELB_STRB: lock_claim_b = 1'b1;
            SELB_NONE, SELB_RSV: ;
        endcase
    end

    // Reset control outranks common drive on the shared pin (R6)
    assign gate_claim   = gate_rst | gate_com;
    assign gate_use_com = gate_com & ~gate_rst;

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            if (LOCK_MASK[i] && (lock_claim_a || lock_claim_b)) begin
                own_o[i] = OWN_LOCK;
            end else if ((i == GATE_PIN) && gate_claim) begin
                own_o[i] = OWN_GATE;
            end else if (dir_q[i]) begin
                own_o[i] = OWN_OUT;
            end else begin
                own_o[i] = OWN_IN;
            end
        end
    end

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_panel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_own_e own_i,
    input  logic     wr_data_en,
    input  logic     wr_bit,
    input  logic     sync_bit,
    input  logic     gate_src,
    input  logic     lcd_bit,
    output logic     data_q,
    output logic     rd_bit,
    output logic     pin_out,
    output logic     pin_oe
);

    // State register: the stored data bit; locked pins drop writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= 1'b0;
        end else if (wr_data_en && (own_i != OWN_LOCK)) begin
            data_q <= wr_bit;
        end
    end

    // Output process: pad drive and read value by ownership class
    always_comb begin
        pin_out = 1'b0;
        pin_oe  = 1'b0;
        rd_bit  = data_q;
        unique case (own_i)
            OWN_IN: begin
                rd_bit = sync_bit;
            end
            OWN_OUT: begin
                pin_out = data_q;
                pin_oe  = 1'b1;
            end
            OWN_GATE: begin
                pin_out = data_q & gate_src;
                pin_oe  = 1'b1;
            end
            OWN_LOCK: begin
                pin_out = lcd_bit;
                pin_oe  = 1'b1;
            end
        endcase
    end

    AST_OUT_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_en && own_i == OWN_OUT) |=> (data_q == $past(wr_bit))); // R2
    AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (own_i == OWN_IN) |-> !pin_oe); // R3
    AST_GATE_FORCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (own_i == OWN_GATE && !data_q) |-> !pin_out); // R5
    AST_LOCK_KEEPS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_en && own_i == OWN_LOCK) |=> (data_q == $past(data_q))); // R7
    AST_CLAIMED_READS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (own_i == OWN_LOCK || own_i == OWN_GATE) |-> (rd_bit == data_q)); // R8

endmodule

// File: rtl/panel_gpio_reg.sv
module panel_gpio_reg
    import gpio_panel_pkg::*;
#(
    parameter int                  NUM_PINS  = 5,
    parameter int                  ADDR_W    = 2,
    parameter int                  GATE_PIN  = 4,
    parameter logic [NUM_PINS-1:0] LOCK_MASK = 5'b01100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [1:0]          sel_a,
    input  logic [1:0]          sel_b,
    input  logic                panel_rst_in,
    input  logic                panel_com_in,
    input  logic [NUM_PINS-1:0] lcd_drv,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_DIR  = ADDR_W'(1);

    logic [NUM_PINS-1:0]     dir_q;
    logic [NUM_PINS-1:0]     data_q;
    logic [NUM_PINS-1:0]     rd_bits;
    logic [NUM_PINS-1:0]     pin_sync;
    pin_own_e [NUM_PINS-1:0] own;
    logic                    gate_use_com;
    logic                    gate_src;
    logic                    wr_data;
    logic                    wr_dir;

    assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
    assign wr_dir   = bus_wr && (bus_addr == ADDR_DIR);
    assign gate_src = gate_use_com ? panel_com_in : panel_rst_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_dir) begin
            dir_q <= bus_wdata;
        end
    end

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    gpio_own_decode #(
        .NUM_PINS  (NUM_PINS),
        .GATE_PIN  (GATE_PIN),
        .LOCK_MASK (LOCK_MASK)
    ) u_decode (
        .sel_a        (sel_a),
        .sel_b        (sel_b),
        .dir_q        (dir_q),
        .own_o        (own),
        .gate_use_com (gate_use_com)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        gpio_pin_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .own_i      (own[g]),
            .wr_data_en (wr_data),
            .wr_bit     (bus_wdata[g]),
            .sync_bit   (pin_sync[g]),
            .gate_src   (gate_src),
            .lcd_bit    (lcd_drv[g]),
            .data_q     (data_q[g]),
            .rd_bit     (rd_bits[g]),
            .pin_out    (pin_out[g]),
            .pin_oe     (pin_oe[g])
        );

        if (!LOCK_MASK[g] && (g != GATE_PIN)) begin : g_free
            AST_FREE_PIN_OE: assert property (@(posedge clk) disable iff (!rst_n)
                pin_oe[g] == dir_q[g]); // R10
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_DATA: bus_rdata = rd_bits;
            ADDR_DIR:  bus_rdata = dir_q;
            default:   bus_rdata = '0;
        endcase
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $rose(rst_n) |-> (dir_q == '0 && data_q == '0)); // R1
    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_q == $past(bus_wdata))); // R9
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q)); // R9
    AST_RST_OUTRANKS_COM: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == 2'b11) |-> (pin_out[GATE_PIN] == (data_q[GATE_PIN] & panel_rst_in))); // R6

endmodule

// File: tb/panel_gpio_reg_test.sv
`timescale 1ns/1ps
module panel_gpio_reg_test;

    typedef struct packed {
        logic [1:0] ma;
        logic [1:0] mb;
        logic       wr;
        logic [1:0] wa;
        logic [4:0] wd;
        logic [1:0] ra;
        logic [4:0] pins;
        logic       rs;
        logic       cs;
        logic [4:0] lcd;
        logic [4:0] eout;
        logic [4:0] eoe;
        logic [4:0] erd;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'b00,2'b00,1'b1,2'd1,5'b10011,2'd1,5'b00100,1'b0,1'b0,5'b00000,5'b00000,5'b10011,5'b10011,4'd9},  // R9 dir write
        '{2'b00,2'b00,1'b1,2'd0,5'b11111,2'd0,5'b00100,1'b0,1'b0,5'b00000,5'b10011,5'b10011,5'b10111,4'd2},  // R2 outputs
        '{2'b00,2'b00,1'b0,2'd0,5'b00000,2'd0,5'b01000,1'b0,1'b0,5'b00000,5'b10011,5'b10011,5'b11011,4'd3},  // R3 inputs
        '{2'b11,2'b00,1'b1,2'd0,5'b00000,2'd0,5'b00000,1'b1,1'b0,5'b01000,5'b01000,5'b11111,5'b01100,4'd7},  // R7 lock, R8
        '{2'b11,2'b00,1'b1,2'd0,5'b10000,2'd0,5'b00000,1'b1,1'b0,5'b01000,5'b11000,5'b11111,5'b11100,4'd5},  // R5 pass
        '{2'b11,2'b00,1'b0,2'd0,5'b00000,2'd0,5'b00000,1'b0,1'b0,5'b01000,5'b01000,5'b11111,5'b11100,4'd5},  // R5 source low
        '{2'b00,2'b10,1'b0,2'd0,5'b00000,2'd0,5'b00000,1'b0,1'b1,5'b00100,5'b10100,5'b11111,5'b11100,4'd6},  // R6 common
        '{2'b11,2'b10,1'b0,2'd0,5'b00000,2'd0,5'b00000,1'b0,1'b1,5'b00100,5'b00100,5'b11111,5'b11100,4'd6},  // R6 priority
        '{2'b10,2'b00,1'b1,2'd0,5'b00011,2'd0,5'b10000,1'b0,1'b0,5'b01100,5'b01111,5'b11111,5'b01111,4'd4},  // R4 fixed
        '{2'b00,2'b01,1'b1,2'd0,5'b10000,2'd0,5'b00000,1'b0,1'b0,5'b00000,5'b10000,5'b11111,5'b11100,4'd4},  // R4 strobe
        '{2'b01,2'b11,1'b1,2'd0,5'b00000,2'd0,5'b01100,1'b1,1'b1,5'b11111,5'b00000,5'b10011,5'b01100,4'd4},  // R4 spare codes
        '{2'b00,2'b00,1'b1,2'd2,5'b11111,2'd2,5'b01100,1'b0,1'b0,5'b00000,5'b00000,5'b10011,5'b00000,4'd9},  // R9 spare addr
        '{2'b11,2'b00,1'b1,2'd1,5'b00000,2'd1,5'b00000,1'b1,1'b0,5'b01100,5'b01100,5'b11100,5'b00000,4'd10}  // R10 free pins
    };

    logic       clk;
    logic       rst_n;
    logic       bus_wr;
    logic [1:0] bus_addr;
    logic [4:0] bus_wdata;
    logic [4:0] bus_rdata;
    logic [1:0] sel_a;
    logic [1:0] sel_b;
    logic       panel_rst_in;
    logic       panel_com_in;
    logic [4:0] lcd_drv;
    logic [4:0] pin_in;
    logic [4:0] pin_out;
    logic [4:0] pin_oe;

    int  checks;
    int  errors;
    bit  done;

    panel_gpio_reg uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .sel_a        (sel_a),
        .sel_b        (sel_b),
        .panel_rst_in (panel_rst_in),
        .panel_com_in (panel_com_in),
        .lcd_drv      (lcd_drv),
        .pin_in       (pin_in),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic run_vec(input int k);
        vec_t v;
        string tag;
        v = VECS[k];
        tag = $sformatf("R%0d vec%0d", v.req, k);
        @(negedge clk);
        sel_a = v.ma; sel_b = v.mb;
        bus_wr = v.wr; bus_addr = v.wa; bus_wdata = v.wd;
        pin_in = v.pins; panel_rst_in = v.rs; panel_com_in = v.cs; lcd_drv = v.lcd;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = v.ra;
        @(negedge clk);
        chk({tag, " pin_out"}, pin_out, v.eout);
        chk({tag, " pin_oe"}, pin_oe, v.eoe);
        chk({tag, " rdata"}, bus_rdata, v.erd);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        checks = 0; errors = 0; done = 1'b0;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
        sel_a = 2'b00; sel_b = 2'b00; panel_rst_in = 1'b0; panel_com_in = 1'b0;
        lcd_drv = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state with no panel mode
        chk("R1 pin_oe", pin_oe, 5'b00000);
        chk("R1 pin_out", pin_out, 5'b00000);
        chk("R1 data read", bus_rdata, 5'b00000);
        bus_addr = 2'd1;
        #1;
        chk("R1 dir read", bus_rdata, 5'b00000);
        // R1: gated reset signal held low by the cleared bit
        sel_a = 2'b11; panel_rst_in = 1'b1; bus_addr = 2'd0;
        #1;
        chk("R1 gated pin low", {4'b0000, pin_out[4]}, 5'b00000);
        @(negedge clk);
        sel_a = 2'b00; panel_rst_in = 1'b0;

        for (int k = 0; k < NV; k++) begin
            run_vec(k);
        end

        // R3: synchronizer latency, two edges
        @(negedge clk);
        sel_a = 2'b00; sel_b = 2'b00; lcd_drv = '0; panel_rst_in = 1'b0;
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 5'b00000; pin_in = 5'b00000;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd0;
        @(negedge clk);
        @(negedge clk);
        chk("R3 settled low", bus_rdata, 5'b00000);
        pin_in = 5'b00001;
        @(negedge clk);
        chk("R3 one edge, not yet", bus_rdata, 5'b00000);
        @(negedge clk);
        chk("R3 two edges, visible", bus_rdata, 5'b00001);
        chk("R3 input not driven", pin_oe, 5'b00000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule